// File: doc/BRIEF.md
# Capture/Match Timer Counter

The block is a general-purpose timer for a peripheral subsystem. A free-running count register advances either once per prescaled clock period (timer mode) or on chosen edges of one of four capture inputs (counter mode). Four capture channels copy the current count when their input shows a selected edge. Four compare channels watch the count and, on equality, can raise an interrupt flag, restart the count, or halt it.

Every compare channel also owns an output pin. In normal use the pin is cleared, set or toggled when its channel hits. In pulse-width mode the pin follows the count instead: it is high while the count is at or above the compare value, which gives a waveform whose period is set by another channel that restarts the count. Interrupt flags are cleared by writing ones. Software configures everything through a simple word-addressed register bus with combinational read data.

Top module: `capmatch_timer`

## Requirements
- R1: After reset every register reads 0, `mat_out` is 0 and `irq` is 0. Word addresses: 0 control, 1 mode, 2 prescale limit, 3 prescale count, 4 count, 5 capture config, 6 compare config, 7 pin control, 8 pulse-width enables, 9 flags, 10..13 compare values 0..3, 14..17 captured values 0..3.
- R2: With control bit 0 (enable) set and mode 0 (timer), the prescale count runs 0..P and the count rises by one on the clock after the prescale count equals P, so after N clocks the count is N/(P+1) and the prescale count is N mod (P+1).
- R3: Control bit 1 (hold) keeps both the count and the prescale count at 0 for as long as it is set; with enable clear the count does not change.
- R4: Mode register bits [1:0] = 01, 10, 11 make the count advance on rising, falling or both edges of the capture input picked by bits [3:2]; inputs pass two synchronising flops first, and edges on other inputs do not count.
- R5: Capture config holds 3 bits per channel n at [3n+2:3n]: bit 0 capture on rising edge, bit 1 capture on falling edge, bit 2 raise flag 4+n. An input change applied before clock edge E is stored at edge E+2 with the count value held just before that edge; an edge kind not selected leaves the captured value unchanged.
- R6: Compare config holds 3 bits per channel n at [3n+2:3n]: bit 0 raise flag n, bit 1 restart, bit 2 halt. When the count reaches compare value M with restart set, the next count step goes to 0 instead of M+1, so the count cycles through M+1 values.
- R7: When the count reaches a compare value with halt set, control bit 0 is cleared on that same clock and the count stays at that value.
- R8: Pin control bits [n] are the pin levels (writable, readable); bits [2n+5:2n+4] are the action of channel n on a hit: 00 none, 01 clear, 10 set, 11 toggle. `mat_out` shows the levels.
- R9: With pulse-width enable bit n set, pin n is high exactly while the count is at least compare value n and its action bits are ignored: value 0 keeps it high, a value equal to the restart value gives one count step high per period, a larger value keeps it low.
- R10: Flags bits 0..3 are compare hits and 4..7 captures; writing 1 to a bit clears it, writing 0 has no effect, and `irq` is the OR of all flags. No flag exists for count wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| cap_in | input | 4 | Capture / count inputs, asynchronous |
| mat_out | output | 4 | Compare pin levels |
| irq | output | 1 | Interrupt request, OR of all flags |

## Verification
A register write takes effect on the clock edge that samples it, so the count has advanced N/(P+1) steps after the Nth edge following the enable write, and pin levels and flags change on the same edge as the count step that caused them. A capture input change is seen two edges later through the synchroniser and stored on the third, holding the count of the cycle before. The bench keeps a running edge counter, notes its value at the enable write, and samples ports and registers half a period after the edge it predicts, computing expected values from those edge offsets.

// File: rtl/capmatch_timer_pkg.sv
package capmatch_timer_pkg;

    localparam int NCH    = 4;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 5;
    localparam int FLAG_W = 2 * NCH;

    localparam logic [ADDR_W-1:0] A_CTRL   = 5'd0;
    localparam logic [ADDR_W-1:0] A_MODE   = 5'd1;
    localparam logic [ADDR_W-1:0] A_PRE    = 5'd2;
    localparam logic [ADDR_W-1:0] A_PCNT   = 5'd3;
    localparam logic [ADDR_W-1:0] A_COUNT  = 5'd4;
    localparam logic [ADDR_W-1:0] A_CAPCFG = 5'd5;
    localparam logic [ADDR_W-1:0] A_CMPCFG = 5'd6;
    localparam logic [ADDR_W-1:0] A_PIN    = 5'd7;
    localparam logic [ADDR_W-1:0] A_PWM    = 5'd8;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 5'd9;
    localparam logic [ADDR_W-1:0] A_CMP0   = 5'd10;
    localparam logic [ADDR_W-1:0] A_CAP0   = A_CMP0 + 5'(NCH);

    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_RISE  = 2'b01,
        MODE_FALL  = 2'b10,
        MODE_BOTH  = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_CLR  = 2'b01,
        ACT_SET  = 2'b10,
        ACT_TGL  = 2'b11
    } pin_act_e;

    typedef struct packed {
        logic halt;
        logic restart;
        logic irq;
    } cmp_cfg_t;

    typedef struct packed {
        logic irq;
        logic fall;
        logic rise;
    } cap_cfg_t;

    function automatic logic pin_next(pin_act_e act, logic lvl);
        case (act)
            ACT_CLR: return 1'b0;
            ACT_SET: return 1'b1;
            ACT_TGL: return ~lvl;
            default: return lvl;
        endcase
    endfunction

endpackage

// File: rtl/capmatch_timer_regs.sv
module capmatch_timer_regs
    import capmatch_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [BUS_W-1:0]              bus_wdata,
    output logic [BUS_W-1:0]              bus_rdata,
    input  logic                          stop_req,
    input  logic [NCH-1:0]                mflag_set,
    input  logic [NCH-1:0]                cflag_set,
    input  logic [CNT_W-1:0]              pc,
    input  logic [CNT_W-1:0]              tc,
    input  logic [NCH-1:0][CNT_W-1:0]     cap_val,
    input  logic [NCH-1:0]                pin_level,
    output logic                          ctrl_en,
    output logic                          ctrl_hold,
    output cnt_mode_e                     mode,
    output logic [1:0]                    capsel,
    output logic [CNT_W-1:0]              pre,
    output cap_cfg_t [NCH-1:0]            cap_cfg,
    output cmp_cfg_t [NCH-1:0]            cmp_cfg,
    output logic [NCH-1:0][1:0]           pin_act,
    output logic                          lvl_we,
    output logic [NCH-1:0]                lvl_wdata,
    output logic [NCH-1:0]                pwm_en,
    output logic [NCH-1:0][CNT_W-1:0]     cmp_val,
    output logic [FLAG_W-1:0]             flags
);

    localparam int CFG_W = 3 * NCH;

    logic [FLAG_W-1:0] flag_clr;

    assign lvl_we    = bus_we && (bus_addr == A_PIN);
    assign lvl_wdata = bus_wdata[NCH-1:0];
    assign flag_clr  = (bus_we && bus_addr == A_FLAGS) ? bus_wdata[FLAG_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en   <= 1'b0;
            ctrl_hold <= 1'b0;
            mode      <= MODE_TIMER;
            capsel    <= '0;
            pre       <= '0;
            cap_cfg   <= '0;
            cmp_cfg   <= '0;
            pin_act   <= '0;
            pwm_en    <= '0;
            cmp_val   <= '0;
            flags     <= '0;
        end else begin
            if (bus_we) begin
                case (bus_addr)
                    A_CTRL: begin
                        ctrl_en   <= bus_wdata[0];
                        ctrl_hold <= bus_wdata[1];
                    end
                    A_MODE: begin
                        mode   <= cnt_mode_e'(bus_wdata[1:0]);
                        capsel <= bus_wdata[3:2];
                    end
                    A_PRE:    pre     <= bus_wdata[CNT_W-1:0];
                    A_CAPCFG: cap_cfg <= bus_wdata[CFG_W-1:0];
                    A_CMPCFG: cmp_cfg <= bus_wdata[CFG_W-1:0];
                    A_PIN:    pin_act <= bus_wdata[3*NCH-1:NCH];
                    A_PWM:    pwm_en  <= bus_wdata[NCH-1:0];
                    default: ;
                endcase
                for (int i = 0; i < NCH; i++) begin
                    if (bus_addr == A_CMP0 + ADDR_W'(i))
                        cmp_val[i] <= bus_wdata[CNT_W-1:0];
                end
            end
            // a halting hit overrides a same-cycle enable write
            if (stop_req)
                ctrl_en <= 1'b0;
            // new events win over a same-cycle clear
            flags <= (flags & ~flag_clr) | {cflag_set, mflag_set};
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:   bus_rdata[1:0]         = {ctrl_hold, ctrl_en};
            A_MODE:   bus_rdata[3:0]         = {capsel, mode};
            A_PRE:    bus_rdata[CNT_W-1:0]   = pre;
            A_PCNT:   bus_rdata[CNT_W-1:0]   = pc;
            A_COUNT:  bus_rdata[CNT_W-1:0]   = tc;
            A_CAPCFG: bus_rdata[CFG_W-1:0]   = cap_cfg;
            A_CMPCFG: bus_rdata[CFG_W-1:0]   = cmp_cfg;
            A_PIN:    bus_rdata[3*NCH-1:0]   = {pin_act, pin_level};
            A_PWM:    bus_rdata[NCH-1:0]     = pwm_en;
            A_FLAGS:  bus_rdata[FLAG_W-1:0]  = flags;
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == A_CMP0 + ADDR_W'(i))
                bus_rdata[CNT_W-1:0] = cmp_val[i];
            if (bus_addr == A_CAP0 + ADDR_W'(i))
                bus_rdata[CNT_W-1:0] = cap_val[i];
        end
    end

endmodule

// File: rtl/capmatch_timer_core.sv
module capmatch_timer_core
    import capmatch_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              hold,
    input  cnt_mode_e         mode,
    input  logic [1:0]        capsel,
    input  logic [CNT_W-1:0]  pre,
    input  logic [NCH-1:0]    edge_rise,
    input  logic [NCH-1:0]    edge_fall,
    input  logic              restart_req,
    output logic [CNT_W-1:0]  pc,
    output logic [CNT_W-1:0]  tc,
    output logic [CNT_W-1:0]  tc_next,
    output logic              step
);

    logic step_src;
    logic restart_pend;
    logic sel_rise;
    logic sel_fall;

    assign sel_rise = edge_rise[capsel];
    assign sel_fall = edge_fall[capsel];

    always_comb begin
        case (mode)
            MODE_RISE: step_src = sel_rise;
            MODE_FALL: step_src = sel_fall;
            MODE_BOTH: step_src = sel_rise | sel_fall;
            default:   step_src = (pc >= pre);
        endcase
    end

    assign step = en && !hold && step_src;

    always_comb begin
        if (hold)
            tc_next = '0;
        else if (step)
            tc_next = restart_pend ? '0 : tc + CNT_W'(1);
        else
            tc_next = tc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc           <= '0;
            tc           <= '0;
            restart_pend <= 1'b0;
        end else begin
            tc <= tc_next;
            if (hold)
                pc <= '0;
            else if (en && mode == MODE_TIMER)
                pc <= (pc >= pre) ? '0 : pc + CNT_W'(1);
            if (hold)
                restart_pend <= 1'b0;
            else if (restart_req)
                restart_pend <= 1'b1;
            else if (step)
                restart_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/capmatch_timer_capture.sv
module capmatch_timer_capture
    import capmatch_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NCH-1:0]            cap_in,
    input  cap_cfg_t [NCH-1:0]        cap_cfg,
    input  logic [CNT_W-1:0]          tc,
    output logic [NCH-1:0]            edge_rise,
    output logic [NCH-1:0]            edge_fall,
    output logic [NCH-1:0][CNT_W-1:0] cap_val,
    output logic [NCH-1:0]            cflag_set
);

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic             sync1, sync2, prev;
        logic             hit;
        logic [CNT_W-1:0] val_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync1 <= 1'b0;
                sync2 <= 1'b0;
                prev  <= 1'b0;
                val_q <= '0;
            end else begin
                sync1 <= cap_in[n];
                sync2 <= sync1;
                prev  <= sync2;
                if (hit)
                    val_q <= tc;
            end
        end

        assign edge_rise[n] = sync2 & ~prev;
        assign edge_fall[n] = ~sync2 & prev;
        assign hit          = (edge_rise[n] & cap_cfg[n].rise) | (edge_fall[n] & cap_cfg[n].fall);
        assign cflag_set[n] = hit & cap_cfg[n].irq;
        assign cap_val[n]   = val_q;
    end

endmodule

// File: rtl/capmatch_timer_match.sv
module capmatch_timer_match
    import capmatch_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      step,
    input  logic [CNT_W-1:0]          tc_next,
    input  logic [NCH-1:0][CNT_W-1:0] cmp_val,
    input  cmp_cfg_t [NCH-1:0]        cmp_cfg,
    input  logic [NCH-1:0][1:0]       pin_act,
    input  logic [NCH-1:0]            pwm_en,
    input  logic                      lvl_we,
    input  logic [NCH-1:0]            lvl_wdata,
    output logic [NCH-1:0]            pin_level,
    output logic [NCH-1:0]            mflag_set,
    output logic                      restart_req,
    output logic                      stop_req
);

    logic [NCH-1:0] hit;
    logic [NCH-1:0] want_restart;
    logic [NCH-1:0] want_halt;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic lvl_q;

        assign hit[n]          = step && (tc_next == cmp_val[n]);
        assign mflag_set[n]    = hit[n] & cmp_cfg[n].irq;
        assign want_restart[n] = hit[n] & cmp_cfg[n].restart;
        assign want_halt[n]    = hit[n] & cmp_cfg[n].halt;

        always_ff @(posedge clk) begin
            if (rst)
                lvl_q <= 1'b0;
            else if (pwm_en[n])
                lvl_q <= (tc_next >= cmp_val[n]);
            else if (hit[n])
                lvl_q <= pin_next(pin_act_e'(pin_act[n]), lvl_q);
            else if (lvl_we)
                lvl_q <= lvl_wdata[n];
        end

        assign pin_level[n] = lvl_q;
    end

    assign restart_req = |want_restart;
    assign stop_req    = |want_halt;

endmodule

// File: rtl/capmatch_timer.sv
module capmatch_timer
    import capmatch_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [3:0]        cap_in,
    output logic [3:0]        mat_out,
    output logic              irq
);

    logic                      ctrl_en, ctrl_hold;
    cnt_mode_e                 mode;
    logic [1:0]                capsel;
    logic [CNT_W-1:0]          pre, pc, tc, tc_next;
    cap_cfg_t [NCH-1:0]        cap_cfg;
    cmp_cfg_t [NCH-1:0]        cmp_cfg;
    logic [NCH-1:0][1:0]       pin_act;
    logic                      lvl_we;
    logic [NCH-1:0]            lvl_wdata;
    logic [NCH-1:0]            pwm_en;
    logic [NCH-1:0][CNT_W-1:0] cmp_val;
    logic [NCH-1:0][CNT_W-1:0] cap_val;
    logic [FLAG_W-1:0]         flags;
    logic [NCH-1:0]            mflag_set, cflag_set;
    logic [NCH-1:0]            edge_rise, edge_fall;
    logic [NCH-1:0]            pin_level;
    logic                      step, restart_req, stop_req;

    capmatch_timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk, .rst, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .stop_req, .mflag_set, .cflag_set, .pc, .tc, .cap_val, .pin_level,
        .ctrl_en, .ctrl_hold, .mode, .capsel, .pre, .cap_cfg, .cmp_cfg,
        .pin_act, .lvl_we, .lvl_wdata, .pwm_en, .cmp_val, .flags
    );

    capmatch_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk, .rst, .en(ctrl_en), .hold(ctrl_hold), .mode, .capsel, .pre,
        .edge_rise, .edge_fall, .restart_req, .pc, .tc, .tc_next, .step
    );

    capmatch_timer_capture #(.CNT_W(CNT_W)) u_cap (
        .clk, .rst, .cap_in, .cap_cfg, .tc, .edge_rise, .edge_fall,
        .cap_val, .cflag_set
    );

    capmatch_timer_match #(.CNT_W(CNT_W)) u_match (
        .clk, .rst, .step, .tc_next, .cmp_val, .cmp_cfg, .pin_act, .pwm_en,
        .lvl_we, .lvl_wdata, .pin_level, .mflag_set, .restart_req, .stop_req
    );

    assign mat_out = pin_level;
    assign irq     = |flags;

endmodule

// File: rtl/capmatch_timer_chk.sv
module capmatch_timer_chk
    import capmatch_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      ctrl_en,
    input logic                      ctrl_hold,
    input logic [CNT_W-1:0]          tc,
    input logic [CNT_W-1:0]          pc,
    input logic [FLAG_W-1:0]         flags,
    input logic [NCH-1:0]            mflag_set,
    input logic [NCH-1:0]            cflag_set,
    input logic                      stop_req,
    input logic [NCH-1:0]            pwm_en,
    input logic [NCH-1:0][CNT_W-1:0] cmp_val,
    input logic [3:0]                mat_out
);

    logic [NCH-1:0] pwm_zero;
    always_comb begin
        for (int i = 0; i < NCH; i++)
            pwm_zero[i] = pwm_en[i] && (cmp_val[i] == '0);
    end

    a_r3_hold_clears: assert property (@(posedge clk) disable iff (rst)
        ctrl_hold |=> (tc == '0 && pc == '0));

    a_r2_count_steps: assert property (@(posedge clk) disable iff (rst)
        (tc != $past(tc)) |-> (tc == $past(tc) + CNT_W'(1) || tc == '0));

    a_r3_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_en && !ctrl_hold) |=> $stable(tc));

    a_r7_halt_disables: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !ctrl_en);

    a_r10_flag_source: assert property (@(posedge clk) disable iff (rst)
        (|(flags & ~$past(flags))) |-> $past(|{mflag_set, cflag_set}));

    a_r9_pwm_zero_high: assert property (@(posedge clk) disable iff (rst)
        (mat_out & $past(pwm_zero)) == $past(pwm_zero));

endmodule

bind capmatch_timer capmatch_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .ctrl_hold(ctrl_hold),
    .tc(tc), .pc(pc), .flags(flags), .mflag_set(mflag_set),
    .cflag_set(cflag_set), .stop_req(stop_req), .pwm_en(pwm_en),
    .cmp_val(cmp_val), .mat_out(mat_out)
);

// File: tb/capmatch_timer_bench.sv
module capmatch_timer_bench;
    import capmatch_timer_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  cap_in = '0;
    logic [3:0]  mat_out;
    logic        irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int w     = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    capmatch_timer u_capmatch_timer (
        .clk, .rst, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .cap_in, .mat_out, .irq
    );

    task automatic chk(string tag, longint got, longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic go();
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h1);
        w = cyc;
    endtask

    task automatic wait_k(int k);
        while (cyc - w < k) @(negedge clk);
    endtask

    task automatic cfg_clear();
        wr(A_CTRL, 32'h2);
        wr(A_MODE, 0); wr(A_PRE, 0); wr(A_CAPCFG, 0); wr(A_CMPCFG, 0);
        wr(A_PIN, 0); wr(A_PWM, 0); wr(A_FLAGS, 32'hFF);
        for (int i = 0; i < NCH; i++) wr(A_CMP0 + 5'(i), 0);
    endtask

    task automatic pulse(int ch);
        cap_in[ch] = 1'b1; repeat (3) @(negedge clk);
        cap_in[ch] = 1'b0; repeat (3) @(negedge clk);
    endtask

    function automatic int exp_period(int k, int p, int m);
        return (k / (p + 1)) % (m + 1);
    endfunction

    function automatic int exp_toggles(int k);
        int c = 0;
        for (int j = 1; j <= k; j++) if (j % 8 == 3) c++;
        return c % 2;
    endfunction

    initial begin
        logic [31:0] d, d2;
        int p, n, m, s, a, k1, kk;
        int pwm_vals[4] = '{0, 2, 5, 7};
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, d);  chk("R1 ctrl", d, 0);
        rd(A_COUNT, d); chk("R1 count", d, 0);
        rd(A_FLAGS, d); chk("R1 flags", d, 0);
        rd(A_CAP0, d);  chk("R1 cap0", d, 0);
        chk("R1 mat_out", mat_out, 0);
        chk("R1 irq", irq, 0);

        // R2 prescaler, random limits and waits
        for (int it = 0; it < 8; it++) begin
            p = $urandom_range(0, 4);
            n = $urandom_range(0, 40);
            cfg_clear();
            wr(A_PRE, p);
            go();
            wait_k(n);
            rd(A_COUNT, d); chk("R2 count", d, n / (p + 1));
            rd(A_PCNT, d);  chk("R2 prescale count", d, n % (p + 1));
        end

        // R3 enable off freezes, hold zeroes
        wr(A_CTRL, 32'h0);
        rd(A_COUNT, d);
        repeat (8) @(negedge clk);
        rd(A_COUNT, d2); chk("R3 frozen count", d2, d);
        wr(A_CTRL, 32'h3);
        repeat (4) @(negedge clk);
        rd(A_COUNT, d); chk("R3 hold count", d, 0);
        rd(A_PCNT, d);  chk("R3 hold prescale", d, 0);

        // R6 restart on compare, period of M+1 steps
        for (int it = 0; it < 4; it++) begin
            p = $urandom_range(0, 2);
            m = $urandom_range(1, 6);
            cfg_clear();
            wr(A_PRE, p); wr(A_CMPCFG, 32'h2); wr(A_CMP0, m);
            go();
            kk = 0;
            for (int j = 0; j < 4; j++) begin
                kk += $urandom_range(1, 15);
                wait_k(kk);
                rd(A_COUNT, d); chk("R6 period count", d, exp_period(kk, p, m));
            end
        end

        // R7 halt on compare channel 1 with flag
        s = $urandom_range(3, 20);
        cfg_clear();
        wr(A_CMPCFG, 32'h28); wr(A_CMP0 + 5'd1, s);
        go();
        wait_k(s + 10);
        rd(A_COUNT, d); chk("R7 halted count", d, s);
        rd(A_CTRL, d);  chk("R7 enable cleared", d & 1, 0);
        rd(A_FLAGS, d); chk("R10 compare flag", d, 32'h2);
        chk("R10 irq on compare", irq, 1);

        // R4 counter mode on input 2
        for (int md = 1; md <= 3; md++) begin
            n = $urandom_range(1, 6);
            cfg_clear();
            wr(A_MODE, md | (2 << 2));
            go();
            pulse(1); pulse(1);
            for (int j = 0; j < n; j++) pulse(2);
            repeat (5) @(negedge clk);
            rd(A_COUNT, d);
            chk("R4 edge count", d, (md == 3) ? 2 * n : n);
        end

        // R5 capture, R10 write-one-to-clear
        cfg_clear();
        wr(A_CAPCFG, 32'h15);
        a = $urandom_range(1, 10);
        go();
        wait_k(a);
        cap_in[0] = 1'b1; cap_in[1] = 1'b1;
        wait_k(a + 6);
        rd(A_CAP0, d);        chk("R5 rising capture", d, a + 2);
        rd(A_CAP0 + 5'd1, d); chk("R5 unselected edge ignored", d, 0);
        rd(A_FLAGS, d);       chk("R5 capture flag", d, 32'h10);
        k1 = cyc - w;
        cap_in[1] = 1'b0; cap_in[0] = 1'b0;
        wait_k(k1 + 6);
        rd(A_CAP0 + 5'd1, d); chk("R5 falling capture", d, k1 + 2);
        rd(A_CAP0, d);        chk("R5 falling ignored on rise channel", d, a + 2);
        wr(A_FLAGS, 32'h0);
        rd(A_FLAGS, d); chk("R10 write zero keeps flag", d, 32'h10);
        chk("R10 irq held", irq, 1);
        wr(A_FLAGS, 32'h10);
        rd(A_FLAGS, d); chk("R10 write one clears", d, 0);
        chk("R10 irq cleared", irq, 0);

        // R8 pin actions: ch1 clear at 5, ch2 toggle at 3, ch3 set at 2, period 8
        cfg_clear();
        wr(A_CMPCFG, 32'h2); wr(A_CMP0, 7); wr(A_CMP0 + 5'd1, 5);
        wr(A_CMP0 + 5'd2, 3); wr(A_CMP0 + 5'd3, 2);
        wr(A_PIN, 32'hB42);
        go();
        for (int k = 1; k <= 20; k++) begin
            wait_k(k);
            chk("R8 pin levels", mat_out,
                {(k >= 2) ? 1'b1 : 1'b0, exp_toggles(k) == 1, (k < 5) ? 1'b1 : 1'b0, 1'b0});
        end
        rd(A_PIN, d); chk("R8 level readback", d & 32'hF, mat_out);

        // R9 pulse-width on ch1, period 6, toggle action ignored
        foreach (pwm_vals[i]) begin
            cfg_clear();
            wr(A_CMPCFG, 32'h2); wr(A_CMP0, 5); wr(A_CMP0 + 5'd1, pwm_vals[i]);
            wr(A_PWM, 32'h2); wr(A_PIN, 32'h3 << 6);
            go();
            for (int k = 1; k <= 13; k++) begin
                wait_k(k);
                chk("R9 pwm level", mat_out[1], ((k % 6) >= pwm_vals[i]) ? 1 : 0);
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule